// File: doc/BRIEF.md
# Thermal Clock-Modulation Throttle Controller

This block produces a clock-enable pattern that slows a processor core down when it runs hot or when software asks for it. Time is split into modulation periods of eight slots, and each slot lasts `SLOT_CYCLES` core cycles. In every period the enable is high for the first few slots and low for the rest. Because the period is counted in core cycles, its length in cycles stays the same at any clock frequency.

There are two throttle sources:

- **Automatic source.** A comparator supplies two flags: one says the temperature is above the trip point, and the other says it is below a lower release point. The block latches an "overheated" state from these two flags. While automatic mode is enabled and that state is set, the enable runs at a fixed half duty.
- **On-demand source.** Software writes a control byte that holds an enable bit and a three-bit duty code, in eighths. This source throttles whatever the temperature.

When both sources ask at once, the automatic source wins. The block picks a new pattern only at a period boundary, so an on-time pulse is never cut short.

Top module: `thermal_throttle`

## Requirements
- R1: Reset does the following:
  - the enable output `clk_gate_en` goes to 1 and `throttle_active` goes to 0;
  - the overheated state and the control byte are cleared;
  - the slot counter starts a new period.
- R2: While no throttle pattern is latched, `clk_gate_en` stays at 1.
- R3: If `auto_en` is 1 and the overheated state is set at a period boundary, the next period is on for slots 0..3 and off for slots 4..7.
- R4: If only the on-demand source is active and its duty code d is between 1 and 7, the next period is on for slots 0..d-1 and off for the remaining slots.
- R5: A duty code of 000 is reserved. It gives the same four-on, four-off pattern as the automatic source.
- R6: If the automatic source and the on-demand source are both active at a boundary, the four-slot automatic pattern is used, whatever the duty code.
- R7: The overheated state works as a hysteresis latch:
  - `temp_trip` sets it (trip wins if both flags are high);
  - `temp_release` alone clears it;
  - with both flags low, it holds its value.
- R8: Source, duty and activity are sampled only in the last cycle of a period. Inside a period, `throttle_active` and the pattern do not change.
- R9: `throttle_active` is 1 exactly when a throttle pattern was latched at the last boundary.
- R10: A write (`ctl_we` = 1) stores the control byte as follows:
  - bit 4 is the on-demand enable;
  - bits 3:1 are the duty code;
  - bits 7:5 and bit 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Enables the automatic throttle source |
| temp_trip | input | 1 | Temperature is above the trip threshold |
| temp_release | input | 1 | Temperature is below the release threshold |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: bit 4 enable, bits 3:1 duty code |
| clk_gate_en | output | 1 | Clock enable for the core |
| throttle_active | output | 1 | A throttle pattern is being applied |

## Verification
The assertions assume the following about the inputs:
- the two comparator flags and the control writes are synchronous to `clk`;
- the flags may be asserted together, in which case the trip flag dominates.

The stimulus drives every input on the falling edge, so the inputs are stable at each rising edge. The random flags are made sparse and the release flag is kept more frequent than the trip flag, so that the overheated state both holds across several periods and clears again.

Control writes use random bytes, including bits 7:5 and bit 0, which the block should ignore. Writes land at arbitrary points in a period, so the boundary-only update is exercised.

// File: rtl/thermal_throttle.sv
module thermal_throttle #(
  parameter int SLOT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       temp_trip,
  input  logic       temp_release,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic       clk_gate_en,
  output logic       throttle_active
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(SLOT_CYCLES - 1);
  localparam logic [2:0] HALF = 3'd4;

  logic [CW-1:0] cyc;
  logic [2:0]    slot;
  logic          hot;
  logic          od_en;
  logic [2:0]    od_duty;
  logic          act_q;
  logic [2:0]    on_q;

  logic       period_end, auto_src, req_act;
  logic [2:0] req_on;

  assign period_end = (slot == 3'd7) && (cyc == CYC_LAST);
  assign auto_src   = auto_en && hot;
  assign req_act    = auto_src || od_en;
  assign req_on     = auto_src ? HALF : ((od_duty == 3'd0) ? HALF : od_duty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= '0;
      slot <= '0;
    end else if (cyc == CYC_LAST) begin
      cyc  <= '0;
      slot <= slot + 3'd1;
    end else begin
      cyc <= cyc + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            hot <= 1'b0;
    else if (temp_trip)    hot <= 1'b1;
    else if (temp_release) hot <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_en   <= 1'b0;
      od_duty <= 3'd0;
    end else if (ctl_we) begin
      od_en   <= ctl_wdata[4];
      od_duty <= ctl_wdata[3:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      on_q  <= 3'd0;
    end else if (period_end) begin
      act_q <= req_act;
      on_q  <= req_on;
    end
  end

  assign clk_gate_en     = !act_q || (slot < on_q);
  assign throttle_active = act_q;
endmodule

// File: rtl/thermal_throttle_chk.sv
module thermal_throttle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_en,
  input logic       temp_trip,
  input logic       temp_release,
  input logic       clk_gate_en,
  input logic       throttle_active,
  input logic       hot,
  input logic       od_en,
  input logic [2:0] od_duty,
  input logic       period_end,
  input logic [2:0] slot,
  input logic [2:0] on_q
);
  a_r2_idle_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
    !throttle_active |-> clk_gate_en);

  a_r4_first_slot_on: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_active && slot == 3'd0) |-> clk_gate_en);

  a_r7_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    temp_trip |=> hot);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!temp_trip && !temp_release) |=> $stable(hot));

  a_r6_auto_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && auto_en && hot) |=> (throttle_active && on_q == 3'd4));

  a_r5_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !(auto_en && hot) && od_en && od_duty == 3'd0) |=> (on_q == 3'd4));

  a_r8_mid_period_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(throttle_active) && $stable(on_q)));
endmodule

bind thermal_throttle thermal_throttle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .temp_trip(temp_trip),
  .temp_release(temp_release), .clk_gate_en(clk_gate_en),
  .throttle_active(throttle_active), .hot(hot), .od_en(od_en),
  .od_duty(od_duty), .period_end(period_end), .slot(slot), .on_q(on_q)
);

// File: tb/sim_thermal_throttle.sv
`timescale 1ns/1ps
module sim_thermal_throttle;
  localparam int N   = 4;
  localparam int PER = 8 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0, temp_trip = 1'b0, temp_release = 1'b0, ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic clk_gate_en, throttle_active;

  int checks = 0, errors = 0;
  bit running = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  thermal_throttle #(.SLOT_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .temp_trip(temp_trip),
    .temp_release(temp_release), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .clk_gate_en(clk_gate_en), .throttle_active(throttle_active)
  );

  // reference model
  int ph = 0;
  bit m_hot = 0, m_od = 0, m_act = 0, m_auto = 0;
  int m_duty = 0, m_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_hot = 0; m_od = 0; m_duty = 0; m_act = 0; m_on = 0; m_auto = 0;
    end else begin
      if (ph == PER - 1) begin
        if (auto_en && m_hot) begin m_act = 1; m_on = 4; m_auto = 1; end
        else if (m_od) begin m_act = 1; m_on = (m_duty == 0) ? 4 : m_duty; m_auto = 0; end
        else begin m_act = 0; m_auto = 0; end
      end
      ph = (ph + 1) % PER;
      if (temp_trip) m_hot = 1;
      else if (temp_release) m_hot = 0;
      if (ctl_we) begin m_od = ctl_wdata[4]; m_duty = int'(ctl_wdata[3:1]); end
    end
  end

  function automatic bit exp_gate();
    return !m_act || ((ph / N) < m_on);
  endfunction

  function automatic string gate_tag();
    if (!m_act) return "R2";
    if (m_auto) return m_od ? "R6" : "R3";
    return (m_duty == 0) ? "R5" : "R4";
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk(gate_tag(), clk_gate_en, exp_gate());
      chk("R9", throttle_active, m_act);
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic pulse_trip();
    @(negedge clk); temp_trip = 1'b1;
    @(negedge clk); temp_trip = 1'b0;
  endtask

  task automatic pulse_release();
    @(negedge clk); temp_release = 1'b1;
    @(negedge clk); temp_release = 1'b0;
  endtask

  task automatic periods(input int n);
    repeat (n * PER) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", clk_gate_en, 1'b1);
    chk("R1", throttle_active, 1'b0);
    rst_n = 1'b1;
    running = 1'b1;
    periods(2);
    // R8: enabling mid-period must not start throttling before the boundary
    while (ph != 5) @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'b0001_0110;
    @(negedge clk); ctl_we = 1'b0;
    chk("R8", throttle_active, 1'b0);
    chk("R8", clk_gate_en, 1'b1);
    periods(3);
    wr(8'b0001_0000); periods(3);              // code 0 -> R5
    wr(8'b0001_1110); periods(3);              // code 7
    wr(8'b0001_0010); periods(3);              // code 1
    wr(8'b0001_1110);
    auto_en = 1'b1; pulse_trip(); periods(3); // R6 precedence
    wr(8'b0000_0000); periods(3);
    chk("R7", throttle_active, 1'b1);          // still hot without release
    pulse_release(); periods(2);
    chk("R7", throttle_active, 1'b0);
    wr(8'hEF); periods(2);                     // bit4 clear, junk bits set
    chk("R10", throttle_active, 1'b0);
    chk("R10", clk_gate_en, 1'b1);
    wr(8'h11); periods(2);                     // enable with code 0, bit0 set
    chk("R10", throttle_active, 1'b1);
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      temp_trip    = ($urandom % 40) == 0;
      temp_release = ($urandom % 25) == 0;
      ctl_we       = ($urandom % 60) == 0;
      ctl_wdata    = 8'($urandom);
      if (($urandom % 300) == 0) auto_en = ~auto_en;
    end
    @(negedge clk);
    temp_trip = 1'b0; temp_release = 1'b0; ctl_we = 1'b0;
    periods(2);
    running = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule